// File: doc/BRIEF.md
# Read Interruption Legality Monitor

This block watches the command bus of a double-data-rate memory, one command per clock, and reports every command that breaks the rules for cutting a read burst short. It knows five commands: no-operation, read, read with auto-precharge, write and burst terminate. The monitor follows the read burst in flight and the distance in cycles to the latest read and the latest terminate. It compares those distances with the burst length, the minimum read-to-read spacing and the CAS latency. The CAS latency is given in half cycles, so a fractional latency rounds up to whole clocks.

Each rule has its own violation bit that stays set until reset. A combined error output is raised during the cycle in which the offending command is on the bus, so a bus model or protocol monitor can stop on the exact command. The block drives no commands and no data, and it has no view of row or refresh timing.

Top module: `ric_checker`

## Requirements
- R1: `cmd_i` is decoded as 0 = no-operation, 1 = read, 2 = read with auto-precharge, 3 = write, 4 = burst terminate. Codes 5, 6 and 7 act as no-operation: they never raise `err_o` and change no tracked state.
- R2: While `rst_ni` is low, `err_o` is 0, `viol_o` is 0, and no burst, spacing window or terminate window is open.
- R3: A read of either kind issued fewer than `TCCD` cycles after the previous read raises `viol_o[0]`.
- R4: A write issued fewer than `BL/2` cycles after the latest plain read, with no terminate in between, raises `viol_o[1]`.
- R5: A read burst ends `BL/2` cycles after its command, so a write issued at that distance or later is legal. A new read restarts the burst window from its own cycle.
- R6: A write issued fewer than ceil(`CL_HALF`/2) cycles after a burst terminate raises `viol_o[2]`. At that distance or later it is legal. A terminate opens this window even when no read is active.
- R7: The latency is rounded up: with `CL_HALF` = 5 (2.5 clocks), a write two cycles after a terminate is flagged and a write three cycles after it is legal.
- R8: A write or a terminate issued while a read with auto-precharge is still in its burst raises `viol_o[3]`, and for that write `viol_o[1]` is not raised.
- R9: A terminate ends the active burst, so a later write is judged only by the terminate gap (R6) and never raises `viol_o[1]`.
- R10: `err_o` is high exactly in the cycles whose command sets at least one violation bit. A violation bit shows from the next cycle and stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Command bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command sampled this cycle (encoding in R1) |
| err_o | output | 1 | High in the cycle of an offending command |
| viol_o | output | 4 | Sticky violation bits: 0 read spacing, 1 write without terminate, 2 terminate-to-write gap, 3 auto-precharge interrupt |

## Verification
The embedded properties check on every cycle the fixed shapes that need only one cycle of history. A read directly after a read, or a write directly after a plain read, must raise the error. An interrupt of an auto-precharge read must set its bit. Idle codes must stay quiet, every error pulse must leave a flag behind, and no flag may ever drop. Only the bench scenarios show the longer-range behaviour. That covers the exact cycle where a burst stops being interruptible, a new read restarting that window, the rounded terminate-to-write distance with a fractional latency, a terminate cancelling the burst, and the exclusion of the write-without-terminate bit under auto-precharge.

// File: rtl/ric_pkg.sv
package ric_pkg;

    typedef enum logic [2:0] {
        CMD_NOP     = 3'd0,
        CMD_READ    = 3'd1,
        CMD_READ_AP = 3'd2,
        CMD_WRITE   = 3'd3,
        CMD_BST     = 3'd4
    } ric_cmd_e;

    localparam int unsigned NUM_RULES = 4;
    localparam int unsigned V_CCD     = 0;
    localparam int unsigned V_NOBST   = 1;
    localparam int unsigned V_GAP     = 2;
    localparam int unsigned V_APRE    = 3;

    typedef struct packed {
        logic [NUM_RULES-1:0] flags;
        logic                 apre;
    } ric_state_t;

endpackage

// File: rtl/ric_cmd_decode.sv
module ric_cmd_decode
    import ric_pkg::*;
(
    input  logic [2:0] cmd_i,
    output logic       is_rd_o,
    output logic       is_ap_o,
    output logic       is_wr_o,
    output logic       is_bst_o
);

    always_comb begin
        is_rd_o  = 1'b0;
        is_ap_o  = 1'b0;
        is_wr_o  = 1'b0;
        is_bst_o = 1'b0;
        case (cmd_i)
            CMD_READ:    is_rd_o = 1'b1;
            CMD_READ_AP: begin
                is_rd_o = 1'b1;
                is_ap_o = 1'b1;
            end
            CMD_WRITE:   is_wr_o  = 1'b1;
            CMD_BST:     is_bst_o = 1'b1;
            default:     ;
        endcase
    end

    // R1: at most one command class is decoded per cycle
    always_comb begin
        a_r1_one_class: assert ($onehot0({is_rd_o, is_wr_o, is_bst_o}));
    end

endmodule

// File: rtl/ric_window.sv
module ric_window #(
    parameter int unsigned LOAD = 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic clear_i,
    output logic busy_o
);

    localparam int unsigned W = $clog2(LOAD + 2);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = W'(LOAD);
        end else if (clear_i) begin
            cnt_d = '0;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);

    // R5: a load opens the window in the next cycle when it has any length
    a_r5_load_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (busy_o == (LOAD != 0)));

    // R9: a clear without a load closes the window
    a_r9_clear_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clear_i && !load_i) |=> !busy_o);

endmodule

// File: rtl/ric_checker.sv
module ric_checker
    import ric_pkg::*;
#(
    parameter int unsigned BL      = 4,
    parameter int unsigned CL_HALF = 6,
    parameter int unsigned TCCD    = 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [2:0]           cmd_i,
    output logic                 err_o,
    output logic [NUM_RULES-1:0] viol_o
);

    localparam int unsigned HALF_BL  = BL / 2;
    localparam int unsigned BURST_LD = (HALF_BL > 0) ? HALF_BL - 1 : 0;
    localparam int unsigned GAP_CLK  = (CL_HALF + 1) / 2;
    localparam int unsigned GAP_LD   = (GAP_CLK > 0) ? GAP_CLK - 1 : 0;
    localparam int unsigned CCD_LD   = (TCCD > 0) ? TCCD - 1 : 0;

    logic is_rd, is_ap, is_wr, is_bst;
    logic burst_act, gap_act, ccd_act;
    logic [NUM_RULES-1:0] hit;
    ric_state_t st_d, st_q;

    ric_cmd_decode u_dec (
        .cmd_i    (cmd_i),
        .is_rd_o  (is_rd),
        .is_ap_o  (is_ap),
        .is_wr_o  (is_wr),
        .is_bst_o (is_bst)
    );

    ric_window #(.LOAD(BURST_LD)) u_burst (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (is_rd),
        .clear_i (is_bst),
        .busy_o  (burst_act)
    );

    ric_window #(.LOAD(GAP_LD)) u_gap (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (is_bst),
        .clear_i (1'b0),
        .busy_o  (gap_act)
    );

    ric_window #(.LOAD(CCD_LD)) u_ccd (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (is_rd),
        .clear_i (1'b0),
        .busy_o  (ccd_act)
    );

    always_comb begin
        hit = '0;
        hit[V_CCD] = is_rd && ccd_act;
        if ((is_wr || is_bst) && burst_act && st_q.apre) begin
            hit[V_APRE] = 1'b1;
        end else if (is_wr && burst_act) begin
            hit[V_NOBST] = 1'b1;
        end
        hit[V_GAP] = is_wr && gap_act;

        st_d       = st_q;
        st_d.flags = st_q.flags | hit;
        if (is_rd) begin
            st_d.apre = is_ap;
        end else if (is_bst) begin
            st_d.apre = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o  = |hit;
    assign viol_o = st_q.flags;

    // R1: idle and unused codes never raise the error
    a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == CMD_NOP || cmd_i > CMD_BST) |-> !err_o);

    // R3: back-to-back reads break any spacing of two or more
    a_r3_back_to_back_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (TCCD >= 2 && is_rd && $past(is_rd) && $past(rst_ni)) |-> err_o);

    // R4: a write right after a plain read interrupts a live burst
    a_r4_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (BL >= 4 && cmd_i == CMD_WRITE && $past(cmd_i) == CMD_READ && $past(rst_ni))
        |=> viol_o[V_NOBST]);

    // R8: write or terminate right after an auto-precharge read
    a_r8_apre_interrupt: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (BL >= 4 && (cmd_i == CMD_WRITE || cmd_i == CMD_BST)
         && $past(cmd_i) == CMD_READ_AP && $past(rst_ni))
        |=> viol_o[V_APRE]);

    // R10: every error pulse leaves a flag behind
    a_r10_pulse_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> (viol_o != '0));

    // R10: flags never drop outside reset
    a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((viol_o & $past(viol_o)) == $past(viol_o)));

endmodule

// File: tb/ric_checker_tb.sv
module ric_checker_tb;

    localparam int CLK_P = 10;

    typedef struct {
        logic       err;
        logic [3:0] flags;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic       err;
    logic [3:0] viol;

    item_t      sb[$];
    logic [3:0] acc = 4'b0;
    int         n_tests = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    ric_checker #(.BL(4), .CL_HALF(5), .TCCD(2)) u_dut (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .cmd_i  (cmd),
        .err_o  (err),
        .viol_o (viol)
    );

    // Driver: one command per cycle, expected result queued with it
    task automatic issue(input logic [2:0] c, input logic [3:0] bits, input string tag);
        item_t it;
        @(negedge clk);
        cmd      = c;
        it.err   = (bits != 4'b0);
        it.flags = acc;
        it.tag   = tag;
        sb.push_back(it);
        acc = acc | bits;
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        cmd   = 3'd0;
        rst_n = 1'b0;
        @(negedge clk);
        #(CLK_P/4);
        n_tests++;
        if (err !== 1'b0 || viol !== 4'b0) begin
            n_fail++;
            $display("FAIL %s: err=%0b viol=%b expected err=0 viol=0000", tag, err, viol);
        end
        acc   = 4'b0;
        rst_n = 1'b1;
    endtask

    // Monitor: compares outputs a quarter period after each command is driven
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_tests++;
                if (err !== it.err || viol !== it.flags) begin
                    n_fail++;
                    $display("FAIL %s: err=%0b viol=%b expected err=%0b viol=%b",
                             it.tag, err, viol, it.err, it.flags);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset("R2 reset state");

        // R1: idle and unused codes
        issue(3'd0, 4'b0000, "R1 nop");
        issue(3'd5, 4'b0000, "R1 code5");
        issue(3'd6, 4'b0000, "R1 code6");
        issue(3'd7, 4'b0000, "R1 code7");
        issue(3'd1, 4'b0000, "R1 read");
        issue(3'd7, 4'b0000, "R1 code7 in burst");
        issue(3'd0, 4'b0000, "R1 flags clear");

        // R3: read spacing of two cycles
        do_reset("R2 reset before R3");
        issue(3'd1, 4'b0000, "R3 first read");
        issue(3'd0, 4'b0000, "R3 gap");
        issue(3'd2, 4'b0000, "R3 read at distance 2");
        issue(3'd1, 4'b0001, "R3 read at distance 1");
        issue(3'd0, 4'b0000, "R10 pulse ends flag stays");
        issue(3'd0, 4'b0000, "R10 flag still set");

        // R4: write into a plain read burst
        do_reset("R2 reset before R4");
        issue(3'd1, 4'b0000, "R4 read");
        issue(3'd3, 4'b0010, "R4 write without terminate");
        issue(3'd0, 4'b0000, "R4 flag visible");

        // R5: burst end and restart
        do_reset("R2 reset before R5");
        issue(3'd1, 4'b0000, "R5 read");
        issue(3'd0, 4'b0000, "R5 gap");
        issue(3'd3, 4'b0000, "R5 write after burst end");
        issue(3'd1, 4'b0000, "R5 read A");
        issue(3'd0, 4'b0000, "R5 gap");
        issue(3'd1, 4'b0000, "R5 read B restarts");
        issue(3'd3, 4'b0010, "R5 write inside restarted burst");
        issue(3'd0, 4'b0000, "R5 flag visible");

        // R6 and R7: terminate gap with rounded latency of 2.5 clocks
        do_reset("R2 reset before R6");
        issue(3'd4, 4'b0000, "R6 idle terminate");
        issue(3'd3, 4'b0100, "R6 write at distance 1");
        issue(3'd0, 4'b0000, "R6 flag visible");
        do_reset("R2 reset before R7");
        issue(3'd4, 4'b0000, "R7 terminate");
        issue(3'd0, 4'b0000, "R7 gap");
        issue(3'd3, 4'b0100, "R7 write at distance 2 rounded");
        issue(3'd0, 4'b0000, "R7 flag visible");
        do_reset("R2 reset before R7 legal");
        issue(3'd4, 4'b0000, "R7 terminate");
        issue(3'd0, 4'b0000, "R7 gap");
        issue(3'd0, 4'b0000, "R7 gap");
        issue(3'd3, 4'b0000, "R7 write at distance 3");
        issue(3'd0, 4'b0000, "R7 no flag");

        // R9: terminate ends the burst
        do_reset("R2 reset before R9");
        issue(3'd1, 4'b0000, "R9 read");
        issue(3'd4, 4'b0000, "R9 terminate");
        issue(3'd0, 4'b0000, "R9 gap");
        issue(3'd0, 4'b0000, "R9 gap");
        issue(3'd3, 4'b0000, "R9 legal write");
        issue(3'd1, 4'b0000, "R9 read");
        issue(3'd4, 4'b0000, "R9 terminate");
        issue(3'd3, 4'b0100, "R9 early write gap only");
        issue(3'd0, 4'b0000, "R9 only gap flag");

        // R8: auto-precharge read cannot be interrupted
        do_reset("R2 reset before R8");
        issue(3'd2, 4'b0000, "R8 read ap");
        issue(3'd4, 4'b1000, "R8 terminate into ap");
        issue(3'd0, 4'b0000, "R8 flag visible");
        do_reset("R2 reset before R8 write");
        issue(3'd2, 4'b0000, "R8 read ap");
        issue(3'd3, 4'b1000, "R8 write into ap not nobst");
        issue(3'd0, 4'b0000, "R8 flag visible");
        do_reset("R2 reset before R8 legal");
        issue(3'd2, 4'b0000, "R8 read ap");
        issue(3'd0, 4'b0000, "R8 gap");
        issue(3'd3, 4'b0000, "R8 write after ap burst");
        issue(3'd0, 4'b0000, "R8 no flag");

        do_reset("R2 reset clears flags");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule